// File: doc/BRIEF.md
# Replay Queue Slot Freelist

This block tracks which slots of a load replay queue are free. It serves several load ports in parallel. Every cycle, each port that raises its request line is handed the index of a free slot, as long as free slots remain. A granted slot leaves the pool at the clock edge that ends the grant cycle. The payload that goes into the slot is written by logic outside this block.

Slots come back through a release bitmap. Any number of bits may be set in one cycle. Those bits are first parked in a pending register. From there they drain back into the pool, at most four per cycle, lowest slot index first. A drained slot can be granted in the cycle after its drain.

Two status outputs report the pool: a registered count of free slots and a full flag. The full flag means the queue has no free slot left. The default configuration has three ports and twenty-four slots.

Top module: `replay_slot_freelist`

## Requirements
- R1: After a synchronous active-high reset, all slots are free, the free count equals the slot count (24), full is 0, and no release is pending.
- R2: A port whose request bit is 0 gets grant valid 0 and takes no slot. With no request at all, the free count does not change.
- R3: Requesting ports receive the lowest-numbered free slots in ascending port order, so a lower port always holds the lower index. For example, with only slots 5 and 10 free and requests on ports 0 and 2, port 0 receives 5 and port 2 receives 10.
- R4: When fewer slots are free than there are requesting ports, the lowest-numbered requesting ports are granted and the remaining requesters see grant valid 0.
- R5: Every granted slot leaves the pool at the clock edge that ends the grant cycle. The free count drops by the number of grants in the next cycle.
- R6: A released slot is not grantable in the cycle after its release bit was set. Pending slots drain at most four per clock edge, lowest index first, and the rest stay pending for later edges.
- R7: A slot released in cycle c drains at the edge ending cycle c+1 and is grantable in cycle c+2.
- R8: full is 1 exactly when the free count is 0. While full is 1, no grant is issued.
- R9: free_count always equals the number of slots that can be granted. It changes only by the drained count minus the granted count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | NUM_PORTS (3) | Per-port slot request for this cycle |
| release_mask | input | NUM_SLOTS (24) | Slots handed back this cycle, one bit per slot |
| grant_vld | output | NUM_PORTS (3) | Per-port grant valid |
| grant_idx | output | NUM_PORTS*IDX_W (15) | Granted slot index per port; port p occupies bits p*IDX_W upward |
| free_count | output | CNT_W (5) | Number of free, grantable slots |
| full | output | 1 | No free slot remains |

## Verification
The assertions assume that release_mask only names slots that are currently allocated. Such a slot is neither free nor pending, and it was not granted in the same cycle. Under that assumption the pool and the pending register never overlap, and the running free count can be compared against the population of the free bitmap. The stimulus meets the assumption by building every release mask from random bits ANDed with the bench's own record of allocated slots. The directed phases release only slots that the bench has just drained out of the pool.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

    localparam int RSF_SLOTS = 24;
    localparam int RSF_PORTS = 3;
    localparam int RSF_DRAIN = 4;

    // Width needed to hold values 0 .. n-1, never below one bit.
    function automatic int bits_for(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Index width for a slot count, and count width able to hold the full count.
    function automatic int idx_bits(input int slots);
        return bits_for(slots);
    endfunction

    function automatic int cnt_bits(input int slots);
        return bits_for(slots + 1);
    endfunction

endpackage

// File: rtl/rsf_pick_chain.sv
// Takes lowest set bits from a pool, one per wanting lane, in lane order.
module rsf_pick_chain #(
    parameter int WIDTH = 24,
    parameter int LANES = 3
) (
    input  logic [WIDTH-1:0]       pool,
    input  logic [LANES-1:0]       want,
    output logic [LANES-1:0]       hit,
    output logic [LANES*WIDTH-1:0] pick_flat
);

    always_comb begin
        logic [WIDTH-1:0] rest;
        logic [WIDTH-1:0] lsb;
        rest      = pool;
        hit       = '0;
        pick_flat = '0;
        for (int l = 0; l < LANES; l++) begin
            lsb = rest & (~rest + WIDTH'(1));
            if (want[l] && (rest != '0)) begin
                hit[l]                     = 1'b1;
                pick_flat[l*WIDTH +: WIDTH] = lsb;
                rest                       = rest & ~lsb;
            end
        end
    end

endmodule

// File: rtl/rsf_drain.sv
// Pending-release register; drains up to DRAIN slots per edge, lowest first.
module rsf_drain #(
    parameter int NUM_SLOTS = 24,
    parameter int DRAIN     = 4,
    parameter int CNT_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] release_mask,
    output logic [NUM_SLOTS-1:0] drained,
    output logic [CNT_W-1:0]     drain_num
);

    logic [NUM_SLOTS-1:0]       pend_q;
    logic [DRAIN-1:0]           lane_hit;
    logic [DRAIN*NUM_SLOTS-1:0] lane_pick;

    rsf_pick_chain #(
        .WIDTH (NUM_SLOTS),
        .LANES (DRAIN)
    ) u_drain_pick (
        .pool      (pend_q),
        .want      ({DRAIN{1'b1}}),
        .hit       (lane_hit),
        .pick_flat (lane_pick)
    );

    always_comb begin
        drained = '0;
        for (int l = 0; l < DRAIN; l++) begin
            drained = drained | lane_pick[l*NUM_SLOTS +: NUM_SLOTS];
        end
        drain_num = CNT_W'($countones(lane_hit));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~drained) | release_mask;
        end
    end

endmodule

// File: rtl/rsf_pool.sv
// Free bitmap and running free count.
module rsf_pool #(
    parameter int NUM_SLOTS = 24,
    parameter int CNT_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] taken,
    input  logic [CNT_W-1:0]     taken_num,
    input  logic [NUM_SLOTS-1:0] returned,
    input  logic [CNT_W-1:0]     returned_num,
    output logic [NUM_SLOTS-1:0] free_vec,
    output logic [CNT_W-1:0]     free_cnt,
    output logic                 empty
);

    always_ff @(posedge clk) begin
        if (rst) begin
            free_vec <= '1;
            free_cnt <= CNT_W'(NUM_SLOTS);
        end else begin
            free_vec <= (free_vec & ~taken) | returned;
            free_cnt <= free_cnt - taken_num + returned_num;
        end
    end

    assign empty = (free_cnt == '0);

endmodule

// File: rtl/replay_slot_freelist.sv
module replay_slot_freelist #(
    parameter int NUM_SLOTS = rsf_pkg::RSF_SLOTS,
    parameter int NUM_PORTS = rsf_pkg::RSF_PORTS,
    parameter int DRAIN     = rsf_pkg::RSF_DRAIN,
    localparam int IDX_W    = rsf_pkg::idx_bits(NUM_SLOTS),
    localparam int CNT_W    = rsf_pkg::cnt_bits(NUM_SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PORTS-1:0]       alloc_req,
    input  logic [NUM_SLOTS-1:0]       release_mask,
    output logic [NUM_PORTS-1:0]       grant_vld,
    output logic [NUM_PORTS*IDX_W-1:0] grant_idx,
    output logic [CNT_W-1:0]           free_count,
    output logic                       full
);

    logic [NUM_SLOTS-1:0]           free_vec;
    logic [NUM_SLOTS-1:0]           drained_vec;
    logic [CNT_W-1:0]               drained_num;
    logic [NUM_SLOTS-1:0]           grant_taken;
    logic [CNT_W-1:0]               grant_num;
    logic [NUM_PORTS*NUM_SLOTS-1:0] grant_pick;

    function automatic logic [IDX_W-1:0] onehot_to_idx(input logic [NUM_SLOTS-1:0] oh);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (oh[i]) r = r | IDX_W'(i);
        end
        return r;
    endfunction

    rsf_pick_chain #(
        .WIDTH (NUM_SLOTS),
        .LANES (NUM_PORTS)
    ) u_grant_pick (
        .pool      (free_vec),
        .want      (alloc_req),
        .hit       (grant_vld),
        .pick_flat (grant_pick)
    );

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_idx
            assign grant_idx[p*IDX_W +: IDX_W] = onehot_to_idx(grant_pick[p*NUM_SLOTS +: NUM_SLOTS]);
        end
    endgenerate

    always_comb begin
        grant_taken = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            grant_taken = grant_taken | grant_pick[p*NUM_SLOTS +: NUM_SLOTS];
        end
        grant_num = CNT_W'($countones(grant_vld));
    end

    rsf_drain #(
        .NUM_SLOTS (NUM_SLOTS),
        .DRAIN     (DRAIN),
        .CNT_W     (CNT_W)
    ) u_drain (
        .clk          (clk),
        .rst          (rst),
        .release_mask (release_mask),
        .drained      (drained_vec),
        .drain_num    (drained_num)
    );

    rsf_pool #(
        .NUM_SLOTS (NUM_SLOTS),
        .CNT_W     (CNT_W)
    ) u_pool (
        .clk          (clk),
        .rst          (rst),
        .taken        (grant_taken),
        .taken_num    (grant_num),
        .returned     (drained_vec),
        .returned_num (drained_num),
        .free_vec     (free_vec),
        .free_cnt     (free_count),
        .empty        (full)
    );

endmodule

// File: rtl/rsf_checker.sv
module rsf_checker #(
    parameter int NUM_SLOTS = 24,
    parameter int NUM_PORTS = 3,
    parameter int DRAIN     = 4,
    parameter int IDX_W     = 5,
    parameter int CNT_W     = 5
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_PORTS-1:0]       alloc_req,
    input logic [NUM_PORTS-1:0]       grant_vld,
    input logic [NUM_PORTS*IDX_W-1:0] grant_idx,
    input logic [CNT_W-1:0]           free_count,
    input logic                       full,
    input logic [NUM_SLOTS-1:0]       free_vec,
    input logic [NUM_SLOTS-1:0]       drained_vec
);

    logic seen_q;
    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= 1'b1;
    end

    assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        (grant_vld & ~alloc_req) == '0);

    assert_full_no_grant_R8: assert property (@(posedge clk) disable iff (rst)
        full |-> (grant_vld == '0));

    assert_drain_bound_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(drained_vec) <= DRAIN);

    assert_count_matches_map_R9: assert property (@(posedge clk) disable iff (rst)
        int'(free_count) == $countones(free_vec));

    assert_count_update_R5: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> int'(free_count) == int'($past(free_count))
                   - $countones($past(grant_vld)) + $countones($past(drained_vec)));

    generate
        for (genvar a = 0; a < NUM_PORTS; a++) begin : g_lo
            for (genvar b = a + 1; b < NUM_PORTS; b++) begin : g_hi
                assert_port_priority_R4: assert property (@(posedge clk) disable iff (rst)
                    (grant_vld[b] && alloc_req[a]) |-> grant_vld[a]);
                assert_idx_ascending_R3: assert property (@(posedge clk) disable iff (rst)
                    (grant_vld[a] && grant_vld[b]) |->
                    (grant_idx[a*IDX_W +: IDX_W] < grant_idx[b*IDX_W +: IDX_W]));
            end
        end
    endgenerate

endmodule

bind replay_slot_freelist rsf_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_PORTS (NUM_PORTS),
    .DRAIN     (DRAIN),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
) u_rsf_chk (
    .clk         (clk),
    .rst         (rst),
    .alloc_req   (alloc_req),
    .grant_vld   (grant_vld),
    .grant_idx   (grant_idx),
    .free_count  (free_count),
    .full        (full),
    .free_vec    (free_vec),
    .drained_vec (drained_vec)
);

// File: tb/replay_slot_freelist_tb.sv
module replay_slot_freelist_tb;

    localparam int S  = 24;
    localparam int P  = 3;
    localparam int IW = 5;
    localparam int CW = 5;

    logic clk = 1'b0;
    logic rst;
    always #5 clk = ~clk;

    logic [P-1:0]    alloc_req;
    logic [S-1:0]    release_mask;
    logic [P-1:0]    grant_vld;
    logic [P*IW-1:0] grant_idx;
    logic [CW-1:0]   free_count;
    logic            full;

    replay_slot_freelist u_dut (
        .clk          (clk),
        .rst          (rst),
        .alloc_req    (alloc_req),
        .release_mask (release_mask),
        .grant_vld    (grant_vld),
        .grant_idx    (grant_idx),
        .free_count   (free_count),
        .full         (full)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [S-1:0] m_free;
    logic [S-1:0] m_pend;
    logic [P-1:0] e_vld;
    int           e_idx [P];
    logic [31:0]  seed = 32'h1bad_5eed;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic model_grants(input logic [P-1:0] req);
        logic [S-1:0] r;
        r = m_free;
        e_vld = '0;
        for (int p = 0; p < P; p++) begin
            e_idx[p] = 0;
            if (req[p] && r != '0) begin
                for (int i = S - 1; i >= 0; i--) if (r[i]) e_idx[p] = i;
                e_vld[p] = 1'b1;
                r[e_idx[p]] = 1'b0;
            end
        end
    endtask

    // One cycle: drive, check combinational and registered outputs, advance model.
    task automatic step(input logic [P-1:0] req, input logic [S-1:0] rel);
        logic [S-1:0] gm;
        logic [S-1:0] dm;
        int nd;
        @(negedge clk);
        alloc_req    = req;
        release_mask = rel;
        #1;
        model_grants(req);
        chk("R4 grant_vld", int'(grant_vld), int'(e_vld));
        for (int p = 0; p < P; p++)
            if (e_vld[p]) chk("R3 grant_idx", int'(grant_idx[p*IW +: IW]), e_idx[p]);
        chk("R9 free_count", int'(free_count), $countones(m_free));
        chk("R8 full", int'(full), int'(m_free == '0));
        gm = '0;
        for (int p = 0; p < P; p++) if (e_vld[p]) gm[e_idx[p]] = 1'b1;
        dm = '0;
        nd = 0;
        for (int i = 0; i < S; i++)
            if (m_pend[i] && nd < 4) begin
                dm[i] = 1'b1;
                nd++;
            end
        m_free = (m_free & ~gm) | dm;
        m_pend = (m_pend & ~dm) | rel;
        @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [S-1:0] alloc;
        logic [31:0]  r1;
        logic [31:0]  r2;
        alloc_req    = '0;
        release_mask = '0;
        rst          = 1'b1;
        m_free       = '1;
        m_pend       = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 free_count after reset", int'(free_count), S);
        chk("R1 full after reset", int'(full), 0);

        step(3'b000, '0);
        #1 chk("R2 no request keeps count", int'(free_count), S);
        step(3'b101, '0);
        #1 chk("R2 idle port takes nothing", int'(free_count), S - 2);
        step(3'b111, '0);
        #1 chk("R5 three grants leave pool", int'(free_count), S - 5);
        while (m_free != '0) step(3'b111, '0);
        #1 chk("R8 full when pool empty", int'(full), 1);
        step(3'b111, '0);

        // Slots 5 and 10 come back; ports 0 and 2 request.
        step(3'b000, (S'(1) << 5) | (S'(1) << 10));
        #1 chk("R6 released slot still pending", int'(free_count), 0);
        step(3'b101, '0);
        #1 chk("R7 slots drained one cycle after release", int'(free_count), 2);
        step(3'b101, '0);
        #1 chk("R7 drained slots granted", int'(free_count), 0);

        // Burst of ten releases drains four per edge.
        step(3'b000, S'(24'h0003FF));
        step(3'b000, '0);
        #1 chk("R6 first drain of four", int'(free_count), 4);
        step(3'b000, '0);
        #1 chk("R6 second drain of four", int'(free_count), 8);
        step(3'b000, '0);
        #1 chk("R6 remaining two drained", int'(free_count), 10);
        step(3'b111, '0);

        // Shortage: one slot, ports 1 and 2 request.
        while ($countones(m_free) > 1) step(3'b001, '0);
        @(negedge clk);
        alloc_req = 3'b110;
        #1;
        chk("R4 only lower requester granted", int'(grant_vld), 3'b010);
        alloc_req = 3'b000;
        step(3'b000, '0);

        for (int k = 0; k < 3000; k++) begin
            r1    = rnd();
            r2    = rnd();
            alloc = ~m_free & ~m_pend;
            step(r1[2:0], r2[S-1:0] & r1[31:8] & alloc);
        end
        repeat (8) step(3'b000, '0);
        #1 chk("R9 final count", int'(free_count), $countones(m_free));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule